// File: doc/BRIEF.md
# Registered Address Buffer with Parity Check

This block sits in the command/address path of a memory module. On every rising clock edge it registers a 28-bit input word. Each registered bit feeds two identical output copies, so one buffer can drive two banks of loads. Two active-low chip-select inputs are also registered, and each of them drives two output copies.

A gate enable input lets the buffer hold its data outputs when no chip-select is active. This saves switching power on idle cycles. The chip-select outputs are registered on every cycle, whether the gate is open or closed.

A parity checker runs next to the data path. The parity bit for a word arrives one clock after the word itself. Even parity is checked over a subset of the data bits, and a configuration input picks that subset. The result appears on an active-low error output two clocks after the word is registered.

Top module: `addr_reg_buf`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high, the next edge clears `qa`, `qb`, `qa_cs_n` and `qb_cs_n` to zero and sets `qerr_n` to 1.
- R2: When `cs_gate_en` is 0, `qa` and `qb` both equal the `d` value sampled at the previous rising edge.
- R3: When `cs_gate_en` is 1 and `cs_n` is 2'b11, `qa` and `qb` keep their previous values across the edge.
- R4: When `cs_gate_en` is 1 and at least one bit of `cs_n` is 0, the data outputs update from `d` as in R2.
- R5: `qa_cs_n` and `qb_cs_n` equal the `cs_n` value sampled at the previous edge, whatever the gate state.
- R6: Parity is even. The word sampled at edge k is paired with the `par_in` sampled at edge k+1. `qerr_n` goes 0 after edge k+2 when the covered bits of that word plus `par_in` hold an odd number of ones, and goes 1 otherwise.
- R7: With `cfg_sel` = 0, parity covers `d` bits 0–4, bit 6, bits 8–11 and bits 16–27 (bit 0 is the first data bit).
- R8: With `cfg_sel` = 1, parity covers `d` bits 0–11, bits 16–19, bit 21 and bits 23–27.
- R9: Data bits outside the covered subset for the selected configuration have no effect on `qerr_n`.
- R10: After reset is released, `qerr_n` stays 1 for the first two edges, until the first word has been paired with its parity bit.
- R11: The coverage subset for a word is chosen by the `cfg_sel` value sampled at the same edge as that word. Changing `cfg_sel` later does not affect that word's check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sel | input | 1 | Selects the parity coverage subset |
| cs_gate_en | input | 1 | Enables holding the data outputs when both chip-selects are idle |
| cs_n | input | 2 | Active-low chip-selects |
| d | input | 28 | Command/address data word |
| par_in | input | 1 | Parity bit for the word from the previous cycle |
| qa | output | 28 | Registered data, copy A |
| qb | output | 28 | Registered data, copy B |
| qa_cs_n | output | 2 | Registered chip-selects, copy A |
| qb_cs_n | output | 2 | Registered chip-selects, copy B |
| qerr_n | output | 1 | Active-low parity error flag |

## Verification
The bench walks a single one through every data bit under both configuration settings. Each bit position is run with both values of the parity bit. A wrong coverage mask shows up as an error flag on an excluded bit, or as a missing flag on a covered bit. A one-cycle slip in pairing word and parity, or in the error-flag delay, gives wrong flags on the random traffic. That traffic toggles the configuration bit between consecutive words, which also exposes a checker that reads the configuration late. Every combination of gate enable and chip-selects is swept, which catches a gate that holds when one chip-select is active. A reset in mid-traffic checks that the error flag is not pulled low and stays quiet until the first new word has been paired with its parity bit.

// File: rtl/abuf_pkg.sv
package abuf_pkg;

    localparam int DATA_W = 28;
    localparam int CS_W   = 2;

    // Parity coverage masks, bit i corresponds to data bit i
    localparam logic [DATA_W-1:0] COVER_CFG0 = 28'hFFF0F5F;
    localparam logic [DATA_W-1:0] COVER_CFG1 = 28'hFAF0FFF;

    // Word held in the parity pipeline together with its configuration
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              cfg;
    } pword_t;

    function automatic logic [DATA_W-1:0] cover_mask(input logic cfg);
        return cfg ? COVER_CFG1 : COVER_CFG0;
    endfunction

    function automatic logic gate_closed(input logic gate_en,
                                         input logic [CS_W-1:0] cs_n);
        return gate_en && (&cs_n);
    endfunction

endpackage

// File: rtl/abuf_out_stage.sv
module abuf_out_stage #(
    parameter int W = abuf_pkg::DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Gated capture register: holds when hold is set, clears on reset
    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (!hold) q <= d;
    end
endmodule

// File: rtl/abuf_parity_pipe.sv
module abuf_parity_pipe #(
    parameter int W = abuf_pkg::DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    input  logic         cfg,
    input  logic         par_in,
    output logic         err_n
);
    import abuf_pkg::*;

    pword_t held_q;     // word captured at edge k
    logic   held_vld;
    logic   odd_q;      // parity result, formed at edge k+1
    logic   odd_vld;
    logic   odd_now;

    always_comb begin
        odd_now = (^(held_q.data & cover_mask(held_q.cfg))) ^ par_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q   <= '0;
            held_vld <= 1'b0;
            odd_q    <= 1'b0;
            odd_vld  <= 1'b0;
            err_n    <= 1'b1;
        end else begin
            held_q   <= '{data: d, cfg: cfg};
            held_vld <= 1'b1;
            odd_q    <= odd_now;
            odd_vld  <= held_vld;
            err_n    <= !(odd_vld && odd_q);
        end
    end
endmodule

// File: rtl/addr_reg_buf.sv
module addr_reg_buf #(
    parameter int DATA_W = abuf_pkg::DATA_W,
    parameter int CS_W   = abuf_pkg::CS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_sel,
    input  logic              cs_gate_en,
    input  logic [CS_W-1:0]   cs_n,
    input  logic [DATA_W-1:0] d,
    input  logic              par_in,
    output logic [DATA_W-1:0] qa,
    output logic [DATA_W-1:0] qb,
    output logic [CS_W-1:0]   qa_cs_n,
    output logic [CS_W-1:0]   qb_cs_n,
    output logic              qerr_n
);
    import abuf_pkg::*;

    localparam int COPIES = 2;

    logic              hold;
    logic [DATA_W-1:0] data_q;
    logic [CS_W-1:0]   cs_q;
    logic [DATA_W-1:0] data_copy [COPIES];
    logic [CS_W-1:0]   cs_copy   [COPIES];

    always_comb hold = gate_closed(cs_gate_en, cs_n);

    abuf_out_stage #(.W(DATA_W)) u_data (
        .clk(clk), .rst(rst), .hold(hold), .d(d), .q(data_q)
    );

    abuf_out_stage #(.W(CS_W)) u_cs (
        .clk(clk), .rst(rst), .hold(1'b0), .d(cs_n), .q(cs_q)
    );

    abuf_parity_pipe #(.W(DATA_W)) u_par (
        .clk(clk), .rst(rst), .d(d), .cfg(cfg_sel),
        .par_in(par_in), .err_n(qerr_n)
    );

    // Fan-out of each registered bit to its output copies
    for (genvar g = 0; g < COPIES; g++) begin : g_copy
        assign data_copy[g] = data_q;
        assign cs_copy[g]   = cs_q;
    end

    assign qa      = data_copy[0];
    assign qb      = data_copy[1];
    assign qa_cs_n = cs_copy[0];
    assign qb_cs_n = cs_copy[1];

endmodule

// File: rtl/addr_reg_buf_chk.sv
module addr_reg_buf_chk #(
    parameter int DATA_W = abuf_pkg::DATA_W,
    parameter int CS_W   = abuf_pkg::CS_W
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_sel,
    input logic              cs_gate_en,
    input logic [CS_W-1:0]   cs_n,
    input logic [DATA_W-1:0] d,
    input logic              par_in,
    input logic [DATA_W-1:0] qa,
    input logic [DATA_W-1:0] qb,
    input logic [CS_W-1:0]   qa_cs_n,
    input logic [CS_W-1:0]   qb_cs_n,
    input logic              qerr_n
);
    import abuf_pkg::*;

    logic [1:0] settle;  // edges seen with reset low, saturating at 3

    always_ff @(posedge clk) begin
        if (rst)              settle <= 2'd0;
        else if (settle != 3) settle <= settle + 2'd1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (qa == '0 && qb == '0 && qa_cs_n == '0 && qb_cs_n == '0 && qerr_n));

    // R2
    open_load_chk: assert property (@(posedge clk) disable iff (rst)
        !gate_closed(cs_gate_en, cs_n) |=> (qa == $past(d) && qb == $past(d)));

    // R3
    gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
        gate_closed(cs_gate_en, cs_n) |=> ($stable(qa) && $stable(qb)));

    // R4
    cs_active_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_gate_en && !(&cs_n)) |=> (qa == $past(d)));

    // R5
    cs_pass_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (qa_cs_n == $past(cs_n) && qb_cs_n == $past(cs_n)));

    // R6
    parity_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (settle == 2'd3) |-> (qerr_n ==
            !((^($past(d, 3) & cover_mask($past(cfg_sel, 3)))) ^ $past(par_in, 2))));

    // R10
    quiet_start_chk: assert property (@(posedge clk) disable iff (rst)
        (settle != 2'd3) |-> qerr_n);

endmodule

bind addr_reg_buf addr_reg_buf_chk #(.DATA_W(DATA_W), .CS_W(CS_W)) u_chk (
    .clk(clk), .rst(rst), .cfg_sel(cfg_sel), .cs_gate_en(cs_gate_en),
    .cs_n(cs_n), .d(d), .par_in(par_in), .qa(qa), .qb(qb),
    .qa_cs_n(qa_cs_n), .qb_cs_n(qb_cs_n), .qerr_n(qerr_n)
);

// File: tb/addr_reg_buf_bench.sv
module addr_reg_buf_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_sel = 1'b0;
    logic        cs_gate_en = 1'b0;
    logic [1:0]  cs_n = 2'b11;
    logic [27:0] d = '0;
    logic        par_in = 1'b0;
    logic [27:0] qa, qb;
    logic [1:0]  qa_cs_n, qb_cs_n;
    logic        qerr_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    addr_reg_buf u_addr_reg_buf (
        .clk(clk), .rst(rst), .cfg_sel(cfg_sel), .cs_gate_en(cs_gate_en),
        .cs_n(cs_n), .d(d), .par_in(par_in), .qa(qa), .qb(qb),
        .qa_cs_n(qa_cs_n), .qb_cs_n(qb_cs_n), .qerr_n(qerr_n)
    );

    // Expected state, advanced once per edge from the requirements
    logic [27:0] m_q = '0;
    logic [1:0]  m_cs = '0;
    logic        m_err = 1'b1;
    logic [27:0] m_pd = '0;
    logic        m_pc = 1'b0;
    logic        m_pv = 1'b0;
    logic        m_odd = 1'b0;
    logic        m_ov = 1'b0;
    string       m_qtag = "R1", m_ptag = "R10", m_otag = "R10", m_etag = "R1";

    // Coverage lists of R7 and R8, data bits numbered from 0
    function automatic bit covered(int n, bit c);
        if (!c) return (n <= 4) || n == 6 || (n >= 8 && n <= 11) || (n >= 16 && n <= 27);
        return (n <= 11) || (n >= 16 && n <= 19) || n == 21 || (n >= 23 && n <= 27);
    endfunction

    function automatic int covered_ones(logic [27:0] w, bit c);
        int cnt = 0;
        for (int i = 0; i < 28; i++) if (w[i] && covered(i, c)) cnt++;
        return cnt;
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock: check outputs of the last edge, then drive the next inputs
    task automatic step(bit r, logic [27:0] dv, bit c, bit p, bit gen, logic [1:0] cs);
        @(negedge clk);
        check(qa == m_q, m_qtag, 32'(qa), 32'(m_q));
        check(qb == m_q, m_qtag, 32'(qb), 32'(m_q));
        check(qa_cs_n == m_cs && qb_cs_n == m_cs, (m_qtag == "R1") ? "R1" : "R5",
              32'({qa_cs_n, qb_cs_n}), 32'({m_cs, m_cs}));
        check(qerr_n == m_err, m_etag, 32'(qerr_n), 32'(m_err));
        rst = r; d = dv; cfg_sel = c; par_in = p; cs_gate_en = gen; cs_n = cs;
        if (r) begin
            m_q = '0; m_cs = '0; m_err = 1'b1; m_pv = 1'b0; m_ov = 1'b0;
            m_pd = '0; m_odd = 1'b0;
            m_qtag = "R1"; m_etag = "R1"; m_ptag = "R10"; m_otag = "R10";
        end else begin
            m_err  = !(m_ov && m_odd);
            m_etag = m_ov ? m_otag : "R10";
            m_odd  = ((covered_ones(m_pd, m_pc) + int'(p)) % 2) == 1;
            m_ov   = m_pv;
            m_otag = m_ptag;
            m_pd = dv; m_pc = c; m_pv = 1'b1;
            if (dv != 0 && covered_ones(dv, c) == 0) m_ptag = "R9";
            else m_ptag = c ? "R8" : "R7";
            if (!(gen && cs == 2'b11)) begin
                m_q = dv;
                m_qtag = gen ? "R4" : "R2";
            end else begin
                m_qtag = "R3";
            end
            m_cs = cs;
        end
    endtask

    initial begin
        // R1: reset state
        repeat (3) step(1, 28'h0, 0, 0, 0, 2'b11);
        // R10: first edges after release
        step(0, 28'h0000001, 0, 1, 0, 2'b10);
        step(0, 28'h0000003, 0, 1, 0, 2'b01);
        // R7, R8, R9: single-bit walk under both settings and both parity values
        for (int c = 0; c < 2; c++)
            for (int b = 0; b < 28; b++)
                for (int p = 0; p < 2; p++)
                    step(0, 28'(1) << b, bit'(c), bit'(p), 0, 2'b00);
        // R2, R3, R4, R5: every gate/chip-select combination
        for (int g = 0; g < 2; g++)
            for (int cs = 0; cs < 4; cs++)
                for (int k = 0; k < 3; k++)
                    step(0, 28'($urandom), bit'(k), 1'b0, bit'(g), 2'(cs));
        // R6, R11: random traffic with the configuration toggling between words
        for (int i = 0; i < 400; i++)
            step(0, 28'($urandom), bit'($urandom), bit'($urandom), bit'($urandom),
                 2'($urandom));
        // R1, R10: reset in mid-traffic, with odd parity pending
        step(0, 28'h0000001, 0, 0, 0, 2'b00);
        step(1, 28'h0000001, 0, 0, 0, 2'b00);
        for (int i = 0; i < 6; i++)
            step(0, 28'h0000001 << i, 1, 0, 0, 2'b10);
        step(0, 28'h0, 0, 0, 0, 2'b11);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule